// File: doc/BRIEF.md
# Quad Converter Double-Buffered Register Front End

This block is the digital side of a four-channel converter, modelled on a system clock. A host writes over an asynchronous parallel bus: an active-low select, an active-low write strobe, a channel address, an 8-bit data byte, a byte-select bit and a gain bit. A write is committed when the write strobe rises while select is low. It lands in the addressed channel's first-stage (staging) register. A second stage, the output code register, feeds the converter. It is loaded from the staging register by an active-low load input, for all channels at once.

The load input supports two ways of working. In the first, load is held low during a write, and the written channel's output follows the write directly. In the second, load is pulsed after one or more writes, and all outputs change together. With the default 10-bit resolution, each code is built from two byte writes: a low byte and a high byte. All bus and control inputs pass through two-flop synchronizers. Because of this, a write reaches the outputs on the third clock edge after the strobe rises.

An active-low clear input and the synchronous reset both zero every register. An active-low power-down input raises a power-down flag and leaves all register contents as they are.

Top module: `dac_quad_frontend`

## Requirements
- R1: A write commits only when the synchronized write strobe goes from low to high while the synchronized select is low. A strobe pulse with select high changes no register. Each strobe pulse commits at most once.
- R2: The address selects the channel: address value n (bit 1 is the MSB) writes channel n, and n runs from 0 to 3. Channel n's code appears on `dac_code[n*10 +: 10]`. A write touches only one channel.
- R3: While load is high and clear is high, no output code changes. A load-low cycle copies every staging register into its output register on the same edge.
- R4: If load is low on the edge where a write commits, the written channel's output register takes the newly written value on that edge. With all inputs stable before the strobe rises, the output changes on the third clock edge after the strobe rise.
- R5: With load held high, a committed write changes no output until a later load pulse.
- R6: Clear low zeroes every staging register, every output register and every gain flag on the next edge. This does not depend on the write strobe. Pending staged data is lost.
- R7: After reset, all codes, all gain flags and the power-down flag read 0.
- R8: With byte-select 1, data bits 1:0 are written to code bits 9:8. With byte-select 0, data bits 7:0 are written to code bits 7:0. The other byte of the staging register keeps its value.
- R9: The gain bit is captured with each write into the channel's staging stage. It moves to `gain_x2[n]` together with the code on load. A value of 1 means twice the reference range.
- R10: Power-down low drives `pwrdn` to 1 after synchronization and back to 0 when released. Register contents are kept, and writes and loads still work while powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low bus select (asynchronous) |
| wr_n | input | 1 | Active-low write strobe; the rising edge commits |
| addr | input | 2 | Channel address |
| data | input | 8 | Write data byte |
| hbyte_sel | input | 1 | 1 selects the upper code byte, 0 the lower |
| gain_sel | input | 1 | Range bit stored with the write |
| ldac_n | input | 1 | Active-low transfer of staging to output registers |
| clr_n | input | 1 | Active-low clear of all registers |
| pd_n | input | 1 | Active-low power-down request |
| dac_code | output | 40 | Four 10-bit output codes, channel 0 in the LSBs |
| gain_x2 | output | 4 | Per-channel range flag of the output stage |
| pwrdn | output | 1 | Power-down flag |

## Verification
The assertions check the following on every cycle:
- at most one channel is targeted per commit, and no commit follows another on the next edge;
- output codes hold while load and clear are both high;
- clear zeroes both stages on the next edge;
- a commit that coincides with load reaches the output register;
- codes stay stable during power-down when there is no load or clear.

Some behaviour only the bench's scenarios can show:
- byte assembly across separate high and low writes;
- the address-to-channel mapping;
- rejection of a strobe while select is high;
- the exact latency from strobe to output;
- loss of staged data when clear is applied.

The bench's per-cycle reference model checks this timing on every clock.

// File: rtl/dacif_pkg.sv
// Shared constants and types for the quad converter register front end.
package dacif_pkg;
    localparam int BYTE_W = 8;

    // Active-low bus control lines, kept together so they synchronize as one vector.
    typedef struct packed {
        logic cs_n;
        logic wr_n;
        logic ldac_n;
        logic clr_n;
        logic pd_n;
    } ctl_t;
endpackage

// File: rtl/dacif_sync.sv
// Two-flop synchronizer for a vector of asynchronous inputs.
// Assumes that each bit is used on its own, or that multi-bit groups are held
// stable by the sender for several clocks around the strobe that qualifies them.
module dacif_sync #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // Two-stage capture into the clock domain, with the idle value on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dacif_wr_decode.sv
// Finds the rising edge of the synchronized write strobe, qualifies it with
// select, and turns it into one per-channel byte-write pulse.
// Assumes the address and byte-select inputs are already synchronized and stable.
module dacif_wr_decode #(
    parameter int NUM_CH = 4,
    parameter int ADDR_W = 2,
    parameter bit SPLIT  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s_n,
    input  logic              wr_s_n,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic              hb_s,
    output logic [NUM_CH-1:0] wr_lo,
    output logic [NUM_CH-1:0] wr_hi
);
    logic wr_q_n;
    logic commit;

    // Delayed copy of the strobe, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) wr_q_n <= 1'b1;
        else        wr_q_n <= wr_s_n;
    end

    // A commit is a low-to-high strobe edge seen while select is low.
    always_comb commit = wr_s_n && !wr_q_n && !cs_s_n;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic hit;
        always_comb hit = commit && (addr_s == ADDR_W'(c));
        if (SPLIT) begin : g_split
            // The byte select steers the pulse to the upper or lower byte.
            always_comb wr_lo[c] = hit && !hb_s;
            always_comb wr_hi[c] = hit &&  hb_s;
        end else begin : g_flat
            // A code of one byte only: the whole word is the low byte.
            always_comb wr_lo[c] = hit;
            always_comb wr_hi[c] = 1'b0;
        end
    end

    assert_single_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_hi, wr_lo}));

    assert_one_commit_per_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (|{wr_hi, wr_lo}) |=> !(|{wr_hi, wr_lo}));
endmodule

// File: rtl/dacif_channel.sv
// One converter channel: a staging register built from byte writes, and an
// output register loaded from it.
// Assumes at most one byte-write pulse per cycle. Clear has priority over
// writes, and a write in a load cycle is passed straight through to the output.
module dacif_channel
    import dacif_pkg::*;
#(
    parameter int RES_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              wr_gain,
    output logic [RES_W-1:0]  dac_code,
    output logic              gain_o
);
    localparam int HI_W = (RES_W > BYTE_W) ? RES_W - BYTE_W : 1;

    logic [RES_W-1:0] stage_code, stage_nxt;
    logic             stage_gain, gain_nxt;

    if (RES_W > BYTE_W) begin : g_split
        // Merge the written byte into the staging word; the other byte is kept.
        always_comb begin
            stage_nxt = stage_code;
            if (wr_lo) stage_nxt[BYTE_W-1:0]     = wr_byte;
            if (wr_hi) stage_nxt[RES_W-1:BYTE_W] = wr_byte[HI_W-1:0];
        end
    end else begin : g_flat
        // A single byte write replaces the whole word.
        always_comb begin
            stage_nxt = stage_code;
            if (wr_lo || wr_hi) stage_nxt = wr_byte[RES_W-1:0];
        end
    end

    // Any byte write also captures the range bit.
    always_comb gain_nxt = (wr_lo || wr_hi) ? wr_gain : stage_gain;

    // Staging stage: cleared by reset or clear, otherwise takes the merged word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            stage_code <= '0;
            stage_gain <= 1'b0;
        end else begin
            stage_code <= stage_nxt;
            stage_gain <= gain_nxt;
        end
    end

    // Output stage: on load it takes the staging word, including a write in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            dac_code <= '0;
            gain_o   <= 1'b0;
        end else if (load) begin
            dac_code <= stage_nxt;
            gain_o   <= gain_nxt;
        end
    end

    assert_hold_without_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !clr) |=> $stable(dac_code));

    assert_clear_zeroes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (dac_code == '0) && (stage_code == '0) && !gain_o);

    assert_sync_write_passes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load && wr_lo && !clr) |=> (dac_code[BYTE_W-1:0] == $past(wr_byte)));
endmodule

// File: rtl/dac_quad_frontend.sv
// Top level of the quad converter register front end. It synchronizes the
// asynchronous bus and control pins, decodes the write strobe, and holds a
// bank of double-buffered channels.
// Assumes the host holds address, data, byte-select and gain stable from
// before the strobe falls until a few clocks after it rises.
module dac_quad_frontend
    import dacif_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int RES_W  = 10
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cs_n,
    input  logic                      wr_n,
    input  logic [1:0]                addr,
    input  logic [7:0]                data,
    input  logic                      hbyte_sel,
    input  logic                      gain_sel,
    input  logic                      ldac_n,
    input  logic                      clr_n,
    input  logic                      pd_n,
    output logic [NUM_CH*RES_W-1:0]   dac_code,
    output logic [NUM_CH-1:0]         gain_x2,
    output logic                      pwrdn
);
    localparam int ADDR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int BUS_W  = ADDR_W + BYTE_W + 2;
    localparam bit SPLIT  = (RES_W > BYTE_W);

    ctl_t             ctl_raw, ctl_s;
    logic [BUS_W-1:0] bus_raw, bus_s;
    logic [ADDR_W-1:0] addr_s;
    logic [BYTE_W-1:0] data_s;
    logic              hb_s, gain_s;
    logic [NUM_CH-1:0] wr_lo, wr_hi;
    logic              load, clr;

    // Gather the raw pins into vectors to be synchronized.
    always_comb begin
        ctl_raw = '{cs_n: cs_n, wr_n: wr_n, ldac_n: ldac_n, clr_n: clr_n, pd_n: pd_n};
        bus_raw = {addr[ADDR_W-1:0], data, hbyte_sel, gain_sel};
    end

    dacif_sync #(.W($bits(ctl_t)), .RST_VAL('1)) i_ctl_sync (
        .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_s)
    );

    dacif_sync #(.W(BUS_W), .RST_VAL('0)) i_bus_sync (
        .clk(clk), .rst_n(rst_n), .d(bus_raw), .q(bus_s)
    );

    // Split the synchronized bus and turn the active-low controls into enables.
    always_comb begin
        {addr_s, data_s, hb_s, gain_s} = bus_s;
        load  = !ctl_s.ldac_n;
        clr   = !ctl_s.clr_n;
        pwrdn = !ctl_s.pd_n;
    end

    dacif_wr_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .SPLIT(SPLIT)) i_decode (
        .clk(clk), .rst_n(rst_n),
        .cs_s_n(ctl_s.cs_n), .wr_s_n(ctl_s.wr_n),
        .addr_s(addr_s), .hb_s(hb_s),
        .wr_lo(wr_lo), .wr_hi(wr_hi)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        dacif_channel #(.RES_W(RES_W)) i_chan (
            .clk(clk), .rst_n(rst_n), .clr(clr), .load(load),
            .wr_lo(wr_lo[c]), .wr_hi(wr_hi[c]),
            .wr_byte(data_s), .wr_gain(gain_s),
            .dac_code(dac_code[c*RES_W +: RES_W]),
            .gain_o(gain_x2[c])
        );
    end

    assert_pd_keeps_codes_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwrdn && !load && !clr) |=> $stable(dac_code));
endmodule

// File: tb/test_dac_quad_frontend.sv
`timescale 1ns/1ps
module test_dac_quad_frontend;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, wr_n = 1'b1, ldac_n = 1'b1, clr_n = 1'b1, pd_n = 1'b1;
    logic [1:0]  addr = '0;
    logic [7:0]  data = '0;
    logic        hbyte_sel = 1'b0, gain_sel = 1'b0;
    logic [39:0] dac_code;
    logic [3:0]  gain_x2;
    logic        pwrdn;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    dac_quad_frontend i_dac_quad_frontend (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
        .data(data), .hbyte_sel(hbyte_sel), .gain_sel(gain_sel),
        .ldac_n(ldac_n), .clr_n(clr_n), .pd_n(pd_n),
        .dac_code(dac_code), .gain_x2(gain_x2), .pwrdn(pwrdn)
    );

    // Reference model: pin history for the two-clock input delay, plus code arrays.
    int m_stage[4], m_out[4];
    bit m_sg[4], m_og[4];
    bit h1_cs, h1_wr, h1_ld, h1_clr, h1_pd, h1_hb, h1_g;
    bit h2_cs, h2_wr, h2_ld, h2_clr, h2_pd, h2_hb, h2_g;
    int h1_a, h1_d, h2_a, h2_d;
    bit m_wrq;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 4; c++) begin
                m_stage[c] = 0; m_out[c] = 0; m_sg[c] = 0; m_og[c] = 0;
            end
            {h1_cs, h1_wr, h1_ld, h1_clr, h1_pd} = 5'b11111;
            {h2_cs, h2_wr, h2_ld, h2_clr, h2_pd} = 5'b11111;
            h1_hb = 0; h1_g = 0; h2_hb = 0; h2_g = 0;
            h1_a = 0; h1_d = 0; h2_a = 0; h2_d = 0;
            m_wrq = 1;
        end else begin
            if (!h2_clr) begin
                for (int c = 0; c < 4; c++) begin
                    m_stage[c] = 0; m_out[c] = 0; m_sg[c] = 0; m_og[c] = 0;
                end
            end else begin
                if (h2_wr && !m_wrq && !h2_cs) begin
                    if (h2_hb) m_stage[h2_a] = (m_stage[h2_a] & 'hFF) | ((h2_d & 3) << 8);
                    else       m_stage[h2_a] = (m_stage[h2_a] & 'h300) | h2_d;
                    m_sg[h2_a] = h2_g;
                end
                if (!h2_ld) begin
                    for (int c = 0; c < 4; c++) begin
                        m_out[c] = m_stage[c]; m_og[c] = m_sg[c];
                    end
                end
            end
            m_wrq = h2_wr;
            {h2_cs, h2_wr, h2_ld, h2_clr, h2_pd, h2_hb, h2_g} = {h1_cs, h1_wr, h1_ld, h1_clr, h1_pd, h1_hb, h1_g};
            h2_a = h1_a; h2_d = h1_d;
            {h1_cs, h1_wr, h1_ld, h1_clr, h1_pd, h1_hb, h1_g} = {cs_n, wr_n, ldac_n, clr_n, pd_n, hbyte_sel, gain_sel};
            h1_a = addr; h1_d = data;
        end
    end

    // Compare every output to the model on each falling edge (R3/R4/R5 timing).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            for (int c = 0; c < 4; c++) begin
                checks++;
                if (int'(dac_code[c*10 +: 10]) != m_out[c] || gain_x2[c] != m_og[c]) begin
                    errors++;
                    $display("FAIL R3 cycle compare ch%0d code %h gain %0d expected %h gain %0d",
                             c, dac_code[c*10 +: 10], gain_x2[c], m_out[c], m_og[c]);
                end
            end
            checks++;
            if (pwrdn != !h2_pd) begin
                errors++;
                $display("FAIL R10 cycle compare pwrdn %0d expected %0d", pwrdn, !h2_pd);
            end
        end
    end

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    function automatic int code(input int c);
        return int'(dac_code[c*10 +: 10]);
    endfunction

    task automatic bus_write(input int ch, input int val, input bit hb, input bit g, input bit sel);
        @(negedge clk);
        addr = 2'(ch); data = 8'(val); hbyte_sel = hb; gain_sel = g; cs_n = !sel;
        @(negedge clk); wr_n = 1'b0;
        repeat (2) @(negedge clk);
        wr_n = 1'b1;
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic load_pulse();
        @(negedge clk); ldac_n = 1'b0;
        @(negedge clk); ldac_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R7: reset state
        chk("R7 codes", int'(dac_code != 0), 0);
        chk("R7 gain", int'(gain_x2), 0);
        chk("R7 pwrdn", int'(pwrdn), 0);

        // R5: an asynchronous-mode write stays staged until a load pulse
        bus_write(1, 'hA5, 0, 0, 1);
        chk("R5 staged not visible", code(1), 0);
        load_pulse();
        chk("R1 R3 load ch1", code(1), 'h0A5);

        // R8: byte assembly
        bus_write(1, 'h02, 1, 0, 1);
        chk("R8 high byte staged", code(1), 'h0A5);
        load_pulse();
        chk("R8 high byte", code(1), 'h2A5);
        bus_write(1, 'hFF, 1, 0, 1);
        bus_write(1, 'h0F, 0, 0, 1);
        load_pulse();
        chk("R8 low byte keeps high", code(1), 'h30F);

        // R4 R9: synchronous mode with gain
        @(negedge clk); ldac_n = 1'b0;
        bus_write(2, 'h3C, 0, 1, 1);
        chk("R4 sync write", code(2), 'h03C);
        chk("R9 gain follows", int'(gain_x2[2]), 1);
        chk("R4 others unchanged", code(1), 'h30F);
        @(negedge clk); ldac_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1: strobe with select high is ignored
        bus_write(3, 'h99, 0, 0, 0);
        load_pulse();
        chk("R1 select high ignored", code(3), 0);

        // R2 R3: all four addresses, one shared load
        bus_write(0, 'h11, 0, 0, 1);
        bus_write(1, 'h22, 0, 0, 1);
        bus_write(2, 'h33, 0, 0, 1);
        bus_write(3, 'h44, 0, 0, 1);
        chk("R3 hold ch0", code(0), 0);
        chk("R3 hold ch2", code(2), 'h03C);
        load_pulse();
        chk("R2 ch0", code(0), 'h011);
        chk("R2 ch1", code(1), 'h322);
        chk("R2 ch2", code(2), 'h033);
        chk("R2 ch3", code(3), 'h044);
        chk("R9 gain cleared by write", int'(gain_x2), 0);

        // R6: clear with a staged write pending
        bus_write(0, 'h55, 0, 1, 1);
        @(negedge clk); clr_n = 1'b0;
        repeat (2) @(negedge clk); clr_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R6 clear codes", int'(dac_code != 0), 0);
        load_pulse();
        chk("R6 staged lost", code(0), 0);
        chk("R6 gain", int'(gain_x2), 0);

        // R10: power-down keeps contents and accepts writes
        bus_write(1, 'h81, 0, 1, 1);
        load_pulse();
        @(negedge clk); pd_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 pwrdn set", int'(pwrdn), 1);
        chk("R10 code kept", code(1), 'h081);
        bus_write(3, 'h07, 0, 0, 1);
        load_pulse();
        chk("R10 write in pd", code(3), 'h007);
        @(negedge clk); pd_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 pwrdn clear", int'(pwrdn), 0);
        chk("R10 kept after", code(1), 'h081);
        chk("R9 gain ch1", int'(gain_x2[1]), 1);

        // R7: reset in the middle of operation
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 reset codes", int'(dac_code != 0), 0);
        chk("R7 reset gain", int'(gain_x2), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule